// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block switches a single power island between its powered and unpowered states. It drives the island's controls in a fixed order, with timed settling gaps between the steps. The controls are a top-level sleep control, an isolation control, a vector of memory-bank power-down fields, a domain reset and a clock enable. Two single-cycle request inputs start the power-on and power-off sequences. A separate shutdown input starts power-off only when the island reports itself as powered. One-cycle acknowledge pulses mark the end of each sequence.

A compile-time choice picks one of two variants. A full island has its own sleep and isolation controls. A memory-only island has neither: it keeps both settling gaps around the memory step and always reports itself as powered. A second choice says whether the island has clocks to gate; an island without clocks skips the long wait before the clock gate. Every wait is a clock-cycle count computed from a clock-frequency parameter and a time in microseconds. At the default settings the short gap is 20 us and the clock-gating wait is 20 ms.

Top module: `pd_sequencer`

## Requirements
- R1: After synchronous reset a full island has sleep_o=1, iso_o=1, every mem_pd_o bit 1, dom_rst_o=1, clk_en_o=0, busy_o=0 and powered_o=0.
- R2: A power-off request accepted at clock edge E sets sleep_o at E. It sets all memory fields at E+S and iso_o at E+2S, where S is the settle count. It then clears clk_en_o and pulses off_ack_o at E+2S+G, where G is the gate count.
- R3: A power-on request accepted at clock edge E clears sleep_o at E and clears all memory fields at E+S. It asserts dom_rst_o at E+2S, clears iso_o at E+2S+1, releases dom_rst_o at E+2S+2, and sets clk_en_o with an on_ack_o pulse at E+2S+3.
- R4: iso_o only falls while dom_rst_o is high, and dom_rst_o only falls after iso_o has been low for a full cycle.
- R5: mem_pd_o is made of 2-bit fields, sixteen per 32-bit word. The value 11 powers a bank down and 00 powers it up, and all fields change together in one cycle.
- R6: For a full island, powered_o is the inverse of sleep_o.
- R7: A memory-only island (HAS_TOP=0) keeps sleep_o and iso_o at 0 and powered_o at 1. It still spaces its memory step by S cycles on each side.
- R8: busy_o is high from the accepting edge until the final step, and on_req, off_req and shutdown have no effect while busy_o is high.
- R9: on_ack_o and off_ack_o are single-cycle pulses that coincide with the fall of busy_o.
- R10: shutdown starts the power-off sequence only when powered_o is 1; otherwise it is ignored.
- R11: When power-on and power-off are requested in the same idle cycle, power-off runs.
- R12: An island without clocks (HAS_CLK=0) holds clk_en_o at 1 and finishes power-off at E+2S, right after isolation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_req | input | 1 | Request to power the island on |
| off_req | input | 1 | Request to power the island off |
| shutdown | input | 1 | System shutdown event; powers off a powered island |
| on_ack | output | 1 | One-cycle pulse at the end of power-on |
| off_ack | output | 1 | One-cycle pulse at the end of power-off |
| busy | output | 1 | Sequence in progress |
| powered | output | 1 | Island power status |
| sleep_o | output | 1 | Top-level sleep control, 1 = asleep |
| iso_o | output | 1 | Isolation control, 1 = isolated |
| mem_pd_o | output | MEM_WORDS*32 | Memory-bank power-down fields |
| dom_rst_o | output | 1 | Domain reset, 1 = held in reset |
| clk_en_o | output | 1 | Domain clock enable |

## Verification
The bench drives two instances from one set of inputs: a full island with clocks and a memory-only island without clocks. The same stimulus therefore shows where the two variants' timings and flag behaviours part ways. The stimulus covers plain on and off requests, a request that arrives while a sequence is running, and shutdown events on a powered and on an unpowered island. It also covers an on and an off request in the same cycle. The latency of each acknowledge separates the on ordering from the off ordering and the gated-clock wait from its absence. The per-cycle comparison against a timeline model catches a step that lands one cycle early or late.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  localparam int unsigned FIELD_W = 2;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_MEM,
    ST_OFF_ISO,
    ST_OFF_GATE,
    ST_ON_MEM,
    ST_ON_RST,
    ST_ON_ISO,
    ST_ON_REL,
    ST_ON_CLK
  } seq_state_t;

  // Cycle count for a wait of 'us' microseconds at 'mhz'; never below one.
  function automatic int unsigned wait_cycles(int unsigned mhz, int unsigned us);
    int unsigned c;
    c = mhz * us;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pd_mem_banks.sv
module pd_mem_banks #(
  parameter int unsigned WORDS   = 2,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_all,
  input  logic                    clr_all,
  output logic [WORDS*WORD_W-1:0] pd
);

  localparam int unsigned FIELDS = WORD_W / FIELD_W;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
      logic [FIELD_W-1:0] field_q;

      always_ff @(posedge clk) begin
        if (rst || set_all) begin
          field_q <= '1;
        end else if (clr_all) begin
          field_q <= '0;
        end
      end

      assign pd[w*WORD_W + f*FIELD_W +: FIELD_W] = field_q;
    end
  end

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter bit              HAS_TOP   = 1'b1,
  parameter bit              HAS_CLK   = 1'b1,
  parameter int unsigned     CNT_W     = 8,
  parameter logic [CNT_W-1:0] SETTLE_LD = '0,
  parameter logic [CNT_W-1:0] GATE_LD   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_req,
  input  logic             off_req,
  input  logic             shutdown,
  input  logic             timer_done,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             mem_set,
  output logic             mem_clr,
  output logic             sleep_q,
  output logic             iso_q,
  output logic             drst_q,
  output logic             clken_q,
  output logic             busy_q,
  output logic             on_ack_q,
  output logic             off_ack_q
);

  seq_state_t state_q, state_d;
  logic       powered_now;
  logic       off_go;
  logic       on_go;
  logic       finish_off;

  assign powered_now = HAS_TOP ? ~sleep_q : 1'b1;
  assign off_go      = off_req | (shutdown & powered_now);
  assign on_go       = on_req & ~off_go;
  assign finish_off  = HAS_CLK ? (state_q == ST_OFF_GATE && timer_done)
                               : (state_q == ST_OFF_ISO && timer_done);

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = SETTLE_LD;
    mem_set    = 1'b0;
    mem_clr    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (off_go) begin
          timer_load = 1'b1;
          state_d    = ST_OFF_MEM;
        end else if (on_go) begin
          timer_load = 1'b1;
          state_d    = ST_ON_MEM;
        end
      end
      ST_OFF_MEM: begin
        if (timer_done) begin
          mem_set    = 1'b1;
          timer_load = 1'b1;
          state_d    = ST_OFF_ISO;
        end
      end
      ST_OFF_ISO: begin
        if (timer_done) begin
          if (HAS_CLK) begin
            timer_load = 1'b1;
            timer_val  = GATE_LD;
            state_d    = ST_OFF_GATE;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_OFF_GATE: begin
        if (timer_done) state_d = ST_IDLE;
      end
      ST_ON_MEM: begin
        if (timer_done) begin
          mem_clr    = 1'b1;
          timer_load = 1'b1;
          state_d    = ST_ON_RST;
        end
      end
      ST_ON_RST: begin
        if (timer_done) state_d = ST_ON_ISO;
      end
      ST_ON_ISO: state_d = ST_ON_REL;
      ST_ON_REL: state_d = ST_ON_CLK;
      ST_ON_CLK: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sleep_q   <= HAS_TOP;
      iso_q     <= HAS_TOP;
      drst_q    <= 1'b1;
      clken_q   <= ~HAS_CLK;
      busy_q    <= 1'b0;
      on_ack_q  <= 1'b0;
      off_ack_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      on_ack_q  <= 1'b0;
      off_ack_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (off_go) begin
          sleep_q <= HAS_TOP;
          busy_q  <= 1'b1;
        end else if (on_go) begin
          sleep_q <= 1'b0;
          busy_q  <= 1'b1;
        end
      end
      if (state_q == ST_OFF_ISO && timer_done) iso_q <= HAS_TOP;
      if (state_q == ST_OFF_GATE && timer_done) clken_q <= 1'b0;
      if (finish_off) begin
        busy_q    <= 1'b0;
        off_ack_q <= 1'b1;
      end
      if (state_q == ST_ON_RST && timer_done) drst_q <= 1'b1;
      if (state_q == ST_ON_ISO) iso_q <= 1'b0;
      if (state_q == ST_ON_REL) drst_q <= 1'b0;
      if (state_q == ST_ON_CLK) begin
        clken_q  <= 1'b1;
        busy_q   <= 1'b0;
        on_ack_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 50,
  parameter int unsigned SETTLE_US = 20,
  parameter int unsigned GATE_US   = 20000,
  parameter int unsigned MEM_WORDS = 2,
  parameter bit          HAS_TOP   = 1'b1,
  parameter bit          HAS_CLK   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          on_req,
  input  logic                          off_req,
  input  logic                          shutdown,
  output logic                          on_ack,
  output logic                          off_ack,
  output logic                          busy,
  output logic                          powered,
  output logic                          sleep_o,
  output logic                          iso_o,
  output logic [MEM_WORDS*WORD_W-1:0]   mem_pd_o,
  output logic                          dom_rst_o,
  output logic                          clk_en_o
);

  localparam int unsigned SETTLE_CYC = wait_cycles(CLK_MHZ, SETTLE_US);
  localparam int unsigned GATE_CYC   = wait_cycles(CLK_MHZ, GATE_US);
  localparam int unsigned MAX_CYC    = (GATE_CYC > SETTLE_CYC) ? GATE_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] GATE_LD   = CNT_W'(GATE_CYC - 1);

  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_done;
  logic             mem_set;
  logic             mem_clr;
  logic             sleep_q;

  pd_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  pd_mem_banks #(
    .WORDS   (MEM_WORDS),
    .WORD_W  (WORD_W),
    .FIELD_W (FIELD_W)
  ) u_banks (
    .clk     (clk),
    .rst     (rst),
    .set_all (mem_set),
    .clr_all (mem_clr),
    .pd      (mem_pd_o)
  );

  pd_seq_fsm #(
    .HAS_TOP   (HAS_TOP),
    .HAS_CLK   (HAS_CLK),
    .CNT_W     (CNT_W),
    .SETTLE_LD (SETTLE_LD),
    .GATE_LD   (GATE_LD)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .on_req     (on_req),
    .off_req    (off_req),
    .shutdown   (shutdown),
    .timer_done (timer_done),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .mem_set    (mem_set),
    .mem_clr    (mem_clr),
    .sleep_q    (sleep_q),
    .iso_q      (iso_o),
    .drst_q     (dom_rst_o),
    .clken_q    (clk_en_o),
    .busy_q     (busy),
    .on_ack_q   (on_ack),
    .off_ack_q  (off_ack)
  );

  assign sleep_o = sleep_q;
  assign powered = HAS_TOP ? ~sleep_q : 1'b1;

endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int unsigned MW      = 64,
  parameter bit          HAS_TOP = 1'b1,
  parameter bit          HAS_CLK = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          on_ack,
  input logic          off_ack,
  input logic          busy,
  input logic          powered,
  input logic          sleep_o,
  input logic          iso_o,
  input logic [MW-1:0] mem_pd_o,
  input logic          dom_rst_o,
  input logic          clk_en_o
);

  // R4: isolation is dropped only with the domain held in reset
  a_r4_iso_fall_in_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_o) |-> dom_rst_o);

  // R4: reset is released only after isolation was already low
  a_r4_release_after_iso: assert property (@(posedge clk) disable iff (rst)
    $fell(dom_rst_o) |-> !$past(iso_o));

  // R9: acknowledges are single-cycle pulses
  a_r9_on_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    on_ack |=> !on_ack);
  a_r9_off_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    off_ack |=> !off_ack);

  // R8: busy ends only together with an acknowledge
  a_r8_busy_end_acked: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (on_ack || off_ack));

  // R3: on completion every bank is up and the domain is out of reset
  a_r3_on_done_state: assert property (@(posedge clk) disable iff (rst)
    on_ack |-> ((mem_pd_o == '0) && !dom_rst_o && !iso_o && clk_en_o));

  // R2: on completion of power-off all banks are down and isolation matches the variant
  a_r2_off_done_state: assert property (@(posedge clk) disable iff (rst)
    off_ack |-> ((&mem_pd_o) && (iso_o == HAS_TOP) && (clk_en_o == !HAS_CLK)));

  // R2: banks go down only after the sleep control is already set
  a_r2_mem_after_sleep: assert property (@(posedge clk) disable iff (rst)
    (HAS_TOP && (&mem_pd_o) && !$past(&mem_pd_o)) |-> sleep_o);

  // R7: memory-only variant never drives sleep or isolation and reports powered
  a_r7_mem_only_flags: assert property (@(posedge clk) disable iff (rst)
    !HAS_TOP |-> (!sleep_o && !iso_o && powered));

endmodule

bind pd_sequencer pd_sequencer_chk #(
  .MW      (MEM_WORDS * pd_seq_pkg::WORD_W),
  .HAS_TOP (HAS_TOP),
  .HAS_CLK (HAS_CLK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .on_ack    (on_ack),
  .off_ack   (off_ack),
  .busy      (busy),
  .powered   (powered),
  .sleep_o   (sleep_o),
  .iso_o     (iso_o),
  .mem_pd_o  (mem_pd_o),
  .dom_rst_o (dom_rst_o),
  .clk_en_o  (clk_en_o)
);

// File: tb/pd_sequencer_test.sv
`timescale 1ns/1ps

// Timeline model: each output is a function of cycles elapsed since the accepting edge.
module pd_ref_model #(
  parameter bit HAS_TOP = 1'b1,
  parameter bit HAS_CLK = 1'b1,
  parameter int S  = 4,
  parameter int G  = 30,
  parameter int MW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          on_req,
  input  logic          off_req,
  input  logic          shutdown,
  output logic          e_on_ack,
  output logic          e_off_ack,
  output logic          e_busy,
  output logic          e_pwr,
  output logic          e_sleep,
  output logic          e_iso,
  output logic [MW-1:0] e_mem,
  output logic          e_rst,
  output logic          e_clk
);
  int mode;
  int el;

  always @(posedge clk) begin
    e_on_ack  = 1'b0;
    e_off_ack = 1'b0;
    if (rst) begin
      mode = 0; el = 0;
      e_sleep = HAS_TOP; e_iso = HAS_TOP; e_mem = '1;
      e_rst = 1'b1; e_clk = !HAS_CLK; e_busy = 1'b0;
    end else if (!e_busy) begin
      if (off_req || (shutdown && e_pwr)) begin
        mode = 2; el = 0; e_busy = 1'b1;
        if (HAS_TOP) e_sleep = 1'b1;
      end else if (on_req) begin
        mode = 1; el = 0; e_busy = 1'b1; e_sleep = 1'b0;
      end
    end else begin
      el = el + 1;
      if (mode == 2) begin
        if (el == S) e_mem = '1;
        if (el == 2*S) begin
          e_iso = HAS_TOP;
          if (!HAS_CLK) begin e_busy = 1'b0; e_off_ack = 1'b1; end
        end
        if (HAS_CLK && el == 2*S + G) begin
          e_clk = 1'b0; e_busy = 1'b0; e_off_ack = 1'b1;
        end
      end else begin
        if (el == S) e_mem = '0;
        if (el == 2*S) e_rst = 1'b1;
        if (el == 2*S + 1) e_iso = 1'b0;
        if (el == 2*S + 2) e_rst = 1'b0;
        if (el == 2*S + 3) begin
          e_clk = 1'b1; e_busy = 1'b0; e_on_ack = 1'b1;
        end
      end
    end
    e_pwr = HAS_TOP ? !e_sleep : 1'b1;
  end
endmodule

module pd_sequencer_test;
  localparam int SA = 4, GA = 30, WA = 2;
  localparam int SB = 3, WB = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on_req = 1'b0, off_req = 1'b0, shutdown = 1'b0;
  always #10 clk = ~clk;

  logic a_on_ack, a_off_ack, a_busy, a_pwr, a_sleep, a_iso, a_rst, a_clk;
  logic [WA*32-1:0] a_mem;
  logic b_on_ack, b_off_ack, b_busy, b_pwr, b_sleep, b_iso, b_rst, b_clk;
  logic [WB*32-1:0] b_mem;

  logic ea_on_ack, ea_off_ack, ea_busy, ea_pwr, ea_sleep, ea_iso, ea_rst, ea_clk;
  logic [WA*32-1:0] ea_mem;
  logic eb_on_ack, eb_off_ack, eb_busy, eb_pwr, eb_sleep, eb_iso, eb_rst, eb_clk;
  logic [WB*32-1:0] eb_mem;

  pd_sequencer #(.CLK_MHZ(1), .SETTLE_US(SA), .GATE_US(GA), .MEM_WORDS(WA),
                 .HAS_TOP(1'b1), .HAS_CLK(1'b1)) uut (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .shutdown(shutdown),
    .on_ack(a_on_ack), .off_ack(a_off_ack), .busy(a_busy), .powered(a_pwr),
    .sleep_o(a_sleep), .iso_o(a_iso), .mem_pd_o(a_mem), .dom_rst_o(a_rst), .clk_en_o(a_clk));

  pd_sequencer #(.CLK_MHZ(1), .SETTLE_US(SB), .GATE_US(GA), .MEM_WORDS(WB),
                 .HAS_TOP(1'b0), .HAS_CLK(1'b0)) uut_mem (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .shutdown(shutdown),
    .on_ack(b_on_ack), .off_ack(b_off_ack), .busy(b_busy), .powered(b_pwr),
    .sleep_o(b_sleep), .iso_o(b_iso), .mem_pd_o(b_mem), .dom_rst_o(b_rst), .clk_en_o(b_clk));

  pd_ref_model #(.HAS_TOP(1'b1), .HAS_CLK(1'b1), .S(SA), .G(GA), .MW(WA*32)) ref_a (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .shutdown(shutdown),
    .e_on_ack(ea_on_ack), .e_off_ack(ea_off_ack), .e_busy(ea_busy), .e_pwr(ea_pwr),
    .e_sleep(ea_sleep), .e_iso(ea_iso), .e_mem(ea_mem), .e_rst(ea_rst), .e_clk(ea_clk));

  pd_ref_model #(.HAS_TOP(1'b0), .HAS_CLK(1'b0), .S(SB), .G(GA), .MW(WB*32)) ref_b (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .shutdown(shutdown),
    .e_on_ack(eb_on_ack), .e_off_ack(eb_off_ack), .e_busy(eb_busy), .e_pwr(eb_pwr),
    .e_sleep(eb_sleep), .e_iso(eb_iso), .e_mem(eb_mem), .e_rst(eb_rst), .e_clk(eb_clk));

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the timeline model.
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R3",  "a.sleep",   64'(a_sleep),   64'(ea_sleep));
      chk("R4",  "a.iso",     64'(a_iso),     64'(ea_iso));
      chk("R4",  "a.dom_rst", 64'(a_rst),     64'(ea_rst));
      chk("R5",  "a.mem",     64'(a_mem),     64'(ea_mem));
      chk("R2",  "a.clk_en",  64'(a_clk),     64'(ea_clk));
      chk("R8",  "a.busy",    64'(a_busy),    64'(ea_busy));
      chk("R9",  "a.on_ack",  64'(a_on_ack),  64'(ea_on_ack));
      chk("R9",  "a.off_ack", 64'(a_off_ack), 64'(ea_off_ack));
      chk("R6",  "a.powered", 64'(a_pwr),     64'(ea_pwr));
      chk("R7",  "b.sleep",   64'(b_sleep),   64'(eb_sleep));
      chk("R7",  "b.iso",     64'(b_iso),     64'(eb_iso));
      chk("R5",  "b.mem",     64'(b_mem),     64'(eb_mem));
      chk("R12", "b.clk_en",  64'(b_clk),     64'(eb_clk));
      chk("R8",  "b.busy",    64'(b_busy),    64'(eb_busy));
      chk("R9",  "b.acks",    64'({b_on_ack, b_off_ack}), 64'({eb_on_ack, eb_off_ack}));
      chk("R7",  "b.powered", 64'(b_pwr),     64'(eb_pwr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Pulse inputs for one cycle, then record the first acknowledge latency of each instance.
  task automatic fire(input logic on, input logic off, input logic sd,
                      output int lat_a, output int lat_b);
    lat_a = -1; lat_b = -1;
    on_req = on; off_req = off; shutdown = sd;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      if (k == 1) begin on_req = 1'b0; off_req = 1'b0; shutdown = 1'b0; end
      if (lat_a < 0 && (a_on_ack || a_off_ack)) lat_a = k;
      if (lat_b < 0 && (b_on_ack || b_off_ack)) lat_b = k;
    end
  endtask

  initial begin
    int la, lb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;

    // R1: reset state of the full island
    chk("R1", "sleep",   64'(a_sleep), 64'd1);
    chk("R1", "iso",     64'(a_iso),   64'd1);
    chk("R1", "mem",     64'(a_mem),   {64{1'b1}});
    chk("R1", "dom_rst", 64'(a_rst),   64'd1);
    chk("R1", "clk_en",  64'(a_clk),   64'd0);
    chk("R1", "busy/pwr", 64'({a_busy, a_pwr}), 64'd0);
    // R7 / R12: memory-only reset flags
    chk("R7",  "mem-only powered/sleep/iso", 64'({b_pwr, b_sleep, b_iso}), 64'b100);
    chk("R12", "no-clock clk_en", 64'(b_clk), 64'd1);

    // R3: power-on latency 2S+3 edges (sampled one negedge later)
    fire(1'b1, 1'b0, 1'b0, la, lb);
    chk("R3", "on latency", 64'(la), 64'(2*SA + 4));
    chk("R7", "mem-only on latency", 64'(lb), 64'(2*SB + 4));
    chk("R5", "banks up after on", 64'(a_mem), 64'd0);

    // R8: off request during a running sequence is ignored
    on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    repeat (2) @(negedge clk);
    off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    repeat (60) @(negedge clk);
    chk("R8", "powered after ignored off", 64'({a_pwr, a_busy}), 64'b10);

    // R10 / R2: shutdown on a powered island runs power-off
    fire(1'b0, 1'b0, 1'b1, la, lb);
    chk("R10", "shutdown off latency", 64'(la), 64'(2*SA + GA + 1));
    chk("R7",  "mem-only off latency", 64'(lb), 64'(2*SB + 1));
    chk("R2",  "off end state", 64'({a_pwr, a_iso, a_clk}), 64'b010);

    // R10: shutdown while unpowered is ignored; memory-only island still powers off
    fire(1'b0, 1'b0, 1'b1, la, lb);
    chk("R10", "shutdown ignored when off", 64'(la), 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R12", "no-clock off latency", 64'(lb), 64'(2*SB + 1));

    // R11: on and off together -> off wins
    fire(1'b1, 1'b0, 1'b0, la, lb);
    fire(1'b1, 1'b1, 1'b0, la, lb);
    chk("R11", "simultaneous picks off", 64'(la), 64'(2*SA + GA + 1));
    chk("R11", "powered after simultaneous", 64'(a_pwr), 64'd0);

    // R2: explicit off request after power-on
    fire(1'b1, 1'b0, 1'b0, la, lb);
    chk("R6", "powered after on", 64'(a_pwr), 64'd1);
    fire(1'b0, 1'b1, 1'b0, la, lb);
    chk("R2", "off_req latency", 64'(la), 64'(2*SA + GA + 1));
    chk("R12", "no-clock clk_en after off", 64'(b_clk), 64'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule